// File: doc/BRIEF.md
# Dithered fine-resolution PWM generator

This block produces one pulse-width-modulated output from a duty word split into two parts: a coarse part that sets the high time of every sub-period in resolution ticks, and a fine part that adds one extra tick to a spread-out subset of the sub-periods. A full output period contains 2^FINE_W sub-periods, and each sub-period lasts 2^COARSE_W ticks. With the default sizes this gives a 14-bit duty value: 8 coarse bits and 6 fine bits. The extra ticks are distributed with a fixed bit-weighted pattern, so that the filtered output tracks the full duty value while the ripple stays at the sub-period rate.

Timing comes from a single-cycle tick-enable input, which an external prescaler generates. Software writes a coarse holding register and a fine holding register. Each holding register is copied into a working latch at its own boundary. The coarse value is copied at the start of every sub-period, and the fine value only at the start of a full period. A status byte returns the fine value currently in use, together with a flag that shows whether a newer fine value is still waiting to be copied. An enable input gates the output.

Top module: `dither_pwm`

## Requirements
- R1: A synchronous reset clears both holding registers, both latches, the tick and sub-period counters and the pending flag. During reset and in the cycle after it, `pwm_out` is 0 and `fine_status` is 0x00.
- R2: In each sub-period the output is high for the first H ticks and low for the rest. H equals the latched coarse value N, plus 1 when the sub-period is extended. N = 0 without an extension gives a sub-period that is low throughout. N = 2^COARSE_W−1 with an extension gives a sub-period that is high throughout.
- R3: Fine bit k extends every sub-period m for which m mod 2^(FINE_W−k) equals 2^(FINE_W−k−1). Sub-period 0 is never extended. With the default sizes, coarse 0x03 and fine 0x05 give 4 high ticks in sub-periods 8, 24, 32, 40 and 56, and 3 high ticks in all the others.
- R4: A coarse write (`wr_coarse`, value taken from `wr_data[COARSE_W-1:0]`) affects the output only from the start of the next sub-period. The sub-period in progress keeps the old value.
- R5: A fine write (`wr_fine`, value taken from `wr_data[FINE_W-1:0]`) affects the output only from the start of the next full period.
- R6: `fine_status[FINE_W-1:0]` holds the latched fine value, and every other bit of `fine_status` below bit 7 reads 0. `fine_status[7]` becomes 1 in the cycle after a fine write and returns to 0 once the value has been copied into the latch at a period boundary.
- R7: While `out_en` is 0, `pwm_out` is 0 from the next cycle onward.
- R8: The counters advance only on cycles where `tick` is 1. `pwm_out` is registered and shows the counter state of the previous cycle, so each tick's level lasts as many clocks as the gap between ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Resolution tick enable, one cycle wide |
| wr_coarse | input | 1 | Write strobe for the coarse holding register |
| wr_fine | input | 1 | Write strobe for the fine holding register |
| wr_data | input | 8 | Write data for either register |
| out_en | input | 1 | Output enable; 0 forces the output low |
| fine_status | output | 8 | Latched fine value in the low bits, pending flag in bit 7 |
| pwm_out | output | 1 | Registered PWM output |

## Verification
The assertions assume that `tick` is a clean single-cycle enable and that a write strobe and a boundary may land in the same cycle. In that case the holding register takes the new value and the latch takes the old one. The bench drives `wr_coarse` and `wr_fine` only between edges, and always lets at least one tick edge pass after a write before it aligns to the next boundary. This keeps the expected latch contents unambiguous. Boundary-straddling writes are placed on purpose at known counter states inside a sub-period or a period, never on the transfer edge itself. The exhaustive sweep uses a reduced configuration (4 coarse bits, 3 fine bits), so that every duty value can be applied, and the full-size configuration is checked with the worked example.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;
  localparam int DATA_W   = 8;
  localparam int STATUS_W = 8;
  localparam int PEND_BIT = 7;
endpackage

// File: rtl/dpwm_timebase.sv
module dpwm_timebase #(
  parameter int CW = 8,
  parameter int FW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  output logic [CW-1:0] tick_cnt,
  output logic [FW-1:0] sub_cnt,
  output logic          sub_end,
  output logic          period_end
);
  localparam logic [CW-1:0] TICK_LAST = '1;
  localparam logic [FW-1:0] SUB_LAST  = '1;

  always_comb begin
    sub_end    = tick && (tick_cnt == TICK_LAST);
    period_end = sub_end && (sub_cnt == SUB_LAST);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tick_cnt <= '0;
      sub_cnt  <= '0;
    end else if (tick) begin
      tick_cnt <= tick_cnt + CW'(1);
      if (tick_cnt == TICK_LAST) sub_cnt <= sub_cnt + FW'(1);
    end
  end

  // R8
  tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(tick_cnt) && $stable(sub_cnt));

  // R8
  sub_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !sub_end |=> $stable(sub_cnt));
endmodule

// File: rtl/dpwm_regs.sv
module dpwm_regs
  import dpwm_pkg::*;
#(
  parameter int CW = 8,
  parameter int FW = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_coarse,
  input  logic              wr_fine,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              sub_end,
  input  logic              period_end,
  output logic [CW-1:0]     coarse_lat,
  output logic [FW-1:0]     fine_lat,
  output logic              pending
);
  logic [CW-1:0] coarse_hold;
  logic [FW-1:0] fine_hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      coarse_hold <= '0;
      fine_hold   <= '0;
      coarse_lat  <= '0;
      fine_lat    <= '0;
      pending     <= 1'b0;
    end else begin
      if (wr_coarse) coarse_hold <= wr_data[CW-1:0];
      if (wr_fine)   fine_hold   <= wr_data[FW-1:0];
      if (sub_end)    coarse_lat <= coarse_hold;
      if (period_end) fine_lat   <= fine_hold;
      if (wr_fine)         pending <= 1'b1;
      else if (period_end) pending <= 1'b0;
    end
  end

  // R4
  coarse_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !sub_end |=> $stable(coarse_lat));

  // R5
  fine_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !period_end |=> $stable(fine_lat));

  // R6
  pend_set_chk: assert property (@(posedge clk) disable iff (rst)
    wr_fine |=> pending);

  // R6
  pend_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (period_end && !wr_fine) |=> !pending);
endmodule

// File: rtl/dpwm_spread.sv
module dpwm_spread #(
  parameter int FW = 6
) (
  input  logic [FW-1:0] sub_cnt,
  input  logic [FW-1:0] fine_lat,
  output logic          extend
);
  logic [FW-1:0] hit;

  for (genvar k = 0; k < FW; k++) begin : g_weight
    localparam int W = FW - k;
    localparam logic [W-1:0] PAT = W'(1) << (W - 1);
    assign hit[k] = fine_lat[k] && (sub_cnt[W-1:0] == PAT);
  end

  assign extend = |hit;

  // R3
  always_comb begin
    if (sub_cnt == '0) zero_sub_chk: assert (!extend);
  end
endmodule

// File: rtl/dither_pwm.sv
module dither_pwm
  import dpwm_pkg::*;
#(
  parameter int COARSE_W = 8,
  parameter int FINE_W   = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick,
  input  logic                wr_coarse,
  input  logic                wr_fine,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic                out_en,
  output logic [STATUS_W-1:0] fine_status,
  output logic                pwm_out
);
  logic [COARSE_W-1:0] tick_cnt;
  logic [FINE_W-1:0]   sub_cnt;
  logic                sub_end, period_end;
  logic [COARSE_W-1:0] coarse_lat;
  logic [FINE_W-1:0]   fine_lat;
  logic                pending, extend;
  logic [COARSE_W:0]   high_len;

  dpwm_timebase #(.CW(COARSE_W), .FW(FINE_W)) u_tb (
    .clk(clk), .rst(rst), .tick(tick), .tick_cnt(tick_cnt),
    .sub_cnt(sub_cnt), .sub_end(sub_end), .period_end(period_end));

  dpwm_regs #(.CW(COARSE_W), .FW(FINE_W)) u_regs (
    .clk(clk), .rst(rst), .wr_coarse(wr_coarse), .wr_fine(wr_fine),
    .wr_data(wr_data), .sub_end(sub_end), .period_end(period_end),
    .coarse_lat(coarse_lat), .fine_lat(fine_lat), .pending(pending));

  dpwm_spread #(.FW(FINE_W)) u_spread (
    .sub_cnt(sub_cnt), .fine_lat(fine_lat), .extend(extend));

  assign high_len = {1'b0, coarse_lat} + (COARSE_W+1)'(extend);

  always_ff @(posedge clk) begin
    if (rst) pwm_out <= 1'b0;
    else     pwm_out <= out_en && ({1'b0, tick_cnt} < high_len);
  end

  always_comb begin
    fine_status = '0;
    fine_status[FINE_W-1:0] = fine_lat;
    fine_status[PEND_BIT]   = pending;
  end

  // R1
  rst_quiet_chk: assert property (@(posedge clk)
    rst |=> !pwm_out && (fine_status == '0));

  // R7
  off_low_chk: assert property (@(posedge clk) disable iff (rst)
    !out_en |=> !pwm_out);

  // R2
  sub_start_chk: assert property (@(posedge clk) disable iff (rst)
    (out_en && tick_cnt == '0 && high_len == '0) |=> !pwm_out);
endmodule

// File: tb/test_dither_pwm.sv
module test_dither_pwm;
  localparam int CLK_PERIOD = 10;
  localparam int SCW = 4, SFW = 3;
  localparam int ST = 1 << SCW, SNS = 1 << SFW, SP = ST * SNS;
  localparam int BT = 256, BNS = 64, BP = BT * BNS;

  logic clk = 1'b0;
  logic rst = 1'b1, tick = 1'b1, out_en = 1'b1;
  logic [7:0] wr_data = '0;
  logic s_wrc = 1'b0, s_wrf = 1'b0, b_wrc = 1'b0, b_wrf = 1'b0;
  logic [7:0] s_stat, b_stat;
  logic s_pwm, b_pwm;

  int gcnt = 0, nvec = 0, nbad = 0, total = 0;
  int subcnt [0:63];

  always #(CLK_PERIOD/2) clk = ~clk;

  dither_pwm #(.COARSE_W(SCW), .FINE_W(SFW)) i_dither_pwm (
    .clk(clk), .rst(rst), .tick(tick), .wr_coarse(s_wrc), .wr_fine(s_wrf),
    .wr_data(wr_data), .out_en(out_en), .fine_status(s_stat), .pwm_out(s_pwm));

  dither_pwm i_dither_pwm_full (
    .clk(clk), .rst(rst), .tick(tick), .wr_coarse(b_wrc), .wr_fine(b_wrf),
    .wr_data(wr_data), .out_en(out_en), .fine_status(b_stat), .pwm_out(b_pwm));

  task automatic step();
    @(posedge clk);
    if (!rst && tick) gcnt++;
    #1;
  endtask

  task automatic check(string req, int act, int exp);
    nvec++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int ext_exp(int m, int f, int fw);
    for (int k = 0; k < fw; k++) begin
      int span = 1 << (fw - k);
      if (((f >> k) & 1) == 1 && (m % span) == span / 2) return 1;
    end
    return 0;
  endfunction

  task automatic align(int p);
    step();
    while (gcnt % p != 0) step();
  endtask

  task automatic write_small(bit coarse, int v);
    wr_data = 8'(v);
    if (coarse) s_wrc = 1'b1; else s_wrf = 1'b1;
    step();
    s_wrc = 1'b0; s_wrf = 1'b0;
  endtask

  // measures one full period of the small instance starting at state 0
  task automatic meas_small(int inj, bit inj_c, int val);
    for (int s = 0; s < 64; s++) subcnt[s] = 0;
    total = 0;
    for (int i = 0; i < SP; i++) begin
      if (i == inj) begin
        wr_data = 8'(val);
        if (inj_c) s_wrc = 1'b1; else s_wrf = 1'b1;
      end
      step();
      s_wrc = 1'b0; s_wrf = 1'b0;
      if (s_pwm) begin subcnt[i / ST]++; total++; end
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (3) step();
    // R1 reset state
    check("R1 pwm_out in reset", int'(s_pwm), 0);
    check("R1 status in reset", int'(s_stat), 0);
    check("R1 full status in reset", int'(b_stat), 0);
    rst = 1'b0;
    gcnt = 0;
    step();
    check("R1 pwm_out after reset", int'(s_pwm), 0);

    // R2 R3 exhaustive sweep over the small configuration
    for (int c = 0; c < ST; c++) begin
      for (int f = 0; f < SNS; f++) begin
        write_small(1'b1, c);
        write_small(1'b0, f);
        align(SP);
        check("R6 status after transfer", int'(s_stat), f);
        meas_small(-1, 1'b0, 0);
        for (int s = 0; s < SNS; s++)
          check("R2 R3 sub-period high ticks", subcnt[s], c + ext_exp(s, f, SFW));
        check("R2 period high ticks", total, c * SNS + f);
      end
    end

    // R4 coarse change inside sub-period 2
    write_small(1'b1, 5);
    write_small(1'b0, 0);
    align(SP);
    meas_small(2 * ST + 3, 1'b1, 9);
    check("R4 sub 1 old coarse", subcnt[1], 5);
    check("R4 sub 2 keeps old coarse", subcnt[2], 5);
    check("R4 sub 3 new coarse", subcnt[3], 9);

    // R5 fine change inside the period
    write_small(1'b1, 2);
    align(SP);
    meas_small(-1, 1'b0, 0);
    meas_small(3 * ST + 1, 1'b0, 7);
    check("R5 period keeps old fine", total, 2 * SNS);
    check("R6 status after boundary", int'(s_stat), 7);
    meas_small(-1, 1'b0, 0);
    check("R5 next period uses new fine", total, 2 * SNS + 7);
    write_small(1'b0, 3);
    check("R6 pending with old fine", int'(s_stat), 128 + 7);
    align(SP);
    check("R6 pending cleared", int'(s_stat), 3);

    // R7 enable gating
    write_small(1'b1, ST - 1);
    write_small(1'b0, SNS - 1);
    out_en = 1'b0;
    align(SP);
    meas_small(-1, 1'b0, 0);
    check("R7 disabled output low", total, 0);
    out_en = 1'b1;
    meas_small(-1, 1'b0, 0);
    check("R7 R2 enabled full-scale", total, (ST - 1) * SNS + SNS - 1);
    check("R2 extended max sub high throughout", subcnt[SNS - 1], ST);

    // R8 sparse ticks: each tick state lasts three clocks
    write_small(1'b1, 6);
    write_small(1'b0, 3);
    align(SP);
    meas_small(-1, 1'b0, 0);
    total = 0;
    for (int i = 0; i < SP; i++) begin
      for (int j = 0; j < 3; j++) begin
        tick = (j == 2);
        step();
        if (s_pwm) total++;
      end
    end
    tick = 1'b1;
    check("R8 high clocks with sparse ticks", total, 3 * (6 * SNS + 3));
    check("R8 period realigned", gcnt % SP, 0);

    // R3 full-size worked example
    wr_data = 8'h03; b_wrc = 1'b1; step(); b_wrc = 1'b0;
    wr_data = 8'h05; b_wrf = 1'b1; step(); b_wrf = 1'b0;
    align(BP);
    check("R6 full-size status", int'(b_stat), 5);
    for (int s = 0; s < 64; s++) subcnt[s] = 0;
    total = 0;
    for (int i = 0; i < BP; i++) begin
      step();
      if (b_pwm) begin subcnt[i / BT]++; total++; end
    end
    for (int s = 0; s < BNS; s++)
      check("R3 full-size sub-period", subcnt[s],
            (s == 8 || s == 24 || s == 32 || s == 40 || s == 56) ? 4 : 3);
    check("R3 full-size period total", total, 3 * BNS + 5);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule